// File: doc/BRIEF.md
# Layer Sequencer for a Tiled Ternary Autoencoder Engine

This block drives the datapath of a small autoencoder engine. The network has a fixed shape. Four convolution layers with stride 2 come first, and one fully-connected layer follows them. The sequencer produces every feature-map read address and every weight read address. It marks where each dot product begins and ends, and it gathers the 2-bit results that come back from the processing elements. It writes those results into feature-map memory as packed words, and the next layer reads them as its input. The PE arithmetic is outside this block.

The PEs are tiled over output channels. Each issued beat carries one feature-map word address, and that word is broadcast to all `NPE` PEs. The beat also carries one weight-word address, which every PE applies to its own weight bank. PE `p` in group `g` therefore computes filter `g*NPE+p`. Weights come straight from weight memory, and no cache holds them. Layer shapes are latched from the configuration ports when the start pulse arrives. Feature maps alternate between two halves of feature-map memory, so a layer never writes into the region it is reading.

Issue beats flow out on a valid/ready pair. While `iss_valid` is high and `iss_ready` is low, the beat and its addresses hold unchanged. The beat transfers on the first clock edge at which both signals are high. Results come back on `res_valid`. The block has no ready signal on that path, and it accepts a result in any cycle.

Top module: `tern_layer_seq`

## Requirements
- R1: After reset, `busy`, `iss_valid`, `fm_wr_en` and `done` are low and `cur_layer` is 0.
- R2: A start pulse while idle runs layers 0 to 4 in order, and `cur_layer` names the layer of every issued beat. Layers 0 to 3 use convolution addressing, and layer 4 uses fully-connected addressing.
- R3: Convolution beats follow this loop order, from outer to inner: output row `oy`, output column `ox`, filter group `g`, kernel row `ky`, kernel column `kx`, channel word `c`. The output size is `(in-k)/2+1` in each dimension. The read offset is `((2*oy+ky)*W + 2*ox+kx)*CW + c`.
- R4: The weight address is a running layer base plus `g*k*k*CW + (ky*k+kx)*CW + c`. The base starts at 0 and grows by `(OC/NPE)*k*k*CW` after each convolution layer.
- R5: The fully-connected layer flattens its input to `L=H*W*CW` words. For each group `g` it reads offsets 0 to `L-1` in order, with weight address base plus `g*L+i`.
- R6: `pe_first` is high on the first beat of each dot product (`ky=kx=c=0`, or `i=0`). `pe_last` is high on the final beat of each dot product. A one-beat product raises both signals.
- R7: A beat that is not accepted holds its addresses and markers stable until it is accepted.
- R8: Each result carries `NPE` 2-bit values, and `VPW/NPE` results fill one word, with the earliest result in the least significant bits. Full words go out on `fm_wr_en` the cycle after the result that completes them, at consecutive addresses.
- R9: Even layers read region 0 (base 0) and write region 1 (base `2^(FM_AW-1)`). Odd layers do the reverse.
- R10: A layer issues no beat until the previous layer's last word has been written. `done` pulses for one cycle, the cycle after the final write of layer 4.
- R11: A start pulse while busy has no effect on the running sequence.
- R12: Changes on the configuration ports after start have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the five-layer pass (ignored while busy) |
| cfg_h | input | 5*DW | Input height per layer, layer l at bits [l*DW +: DW] |
| cfg_w | input | 5*DW | Input width per layer |
| cfg_cw | input | 5*DW | Input channel words per layer |
| cfg_k | input | 5*DW | Kernel size per convolution layer |
| cfg_oc | input | 5*DW | Output channels per layer (a multiple of VPW) |
| busy | output | 1 | Pass in progress |
| cur_layer | output | 3 | Layer being processed |
| iss_valid | output | 1 | Issue beat valid |
| iss_ready | input | 1 | Memories and PEs accept the beat |
| fm_rd_addr | output | FM_AW | Feature-map word read address |
| wt_addr | output | WT_AW | Weight word address, shared by all PE banks |
| pe_first | output | 1 | First beat of a dot product |
| pe_last | output | 1 | Last beat of a dot product |
| res_valid | input | 1 | PE result valid |
| res_data | input | 2*NPE | One 2-bit value per PE, PE 0 lowest |
| fm_wr_en | output | 1 | Feature-map write strobe |
| fm_wr_addr | output | FM_AW | Feature-map write address |
| fm_wr_data | output | 2*VPW | Packed output word |
| done | output | 1 | One-cycle pulse at the end of the pass |

## Verification
The bench builds the block with NPE=2 and VPW=4, so two results make one packed word. Slot ordering and word boundaries therefore change every other result. DW=6 and FM_AW=12 give two 2048-word regions, and the high address bit alone shows which region a layer uses. With shapes of up to nine pixels per side, the bench reaches several corners with short runs: one-beat dot products, one-pixel layers, kernels as large as the input, and tall fully-connected vectors.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
  localparam int NUM_LAYERS = 5;
  localparam int NUM_CONV   = 4;
  localparam int LAYER_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/seqr_conv_agen.sv
module seqr_conv_agen #(
  parameter int DW     = 6,
  parameter int OFF_W  = 11,
  parameter int WOFF_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [DW-1:0]     in_w,
  input  logic [DW-1:0]     in_cw,
  input  logic [DW-1:0]     ksz,
  input  logic [DW-1:0]     out_h,
  input  logic [DW-1:0]     out_w,
  input  logic [DW-1:0]     groups,
  output logic [OFF_W-1:0]  fm_off,
  output logic [WOFF_W-1:0] wt_off,
  output logic              beat_first,
  output logic              beat_last,
  output logic              layer_end
);
  logic [DW-1:0] oy, ox, grp, ky, kx, cw;
  logic cw_w, kx_w, ky_w, g_w, ox_w, oy_w;

  assign cw_w = (cw  == in_cw  - DW'(1));
  assign kx_w = (kx  == ksz    - DW'(1));
  assign ky_w = (ky  == ksz    - DW'(1));
  assign g_w  = (grp == groups - DW'(1));
  assign ox_w = (ox  == out_w  - DW'(1));
  assign oy_w = (oy  == out_h  - DW'(1));

  // Loop nest, innermost first: channel word, kx, ky, group, ox, oy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oy <= '0; ox <= '0; grp <= '0; ky <= '0; kx <= '0; cw <= '0;
    end else if (clr) begin
      oy <= '0; ox <= '0; grp <= '0; ky <= '0; kx <= '0; cw <= '0;
    end else if (step) begin
      if (!cw_w) cw <= cw + DW'(1);
      else begin
        cw <= '0;
        if (!kx_w) kx <= kx + DW'(1);
        else begin
          kx <= '0;
          if (!ky_w) ky <= ky + DW'(1);
          else begin
            ky <= '0;
            if (!g_w) grp <= grp + DW'(1);
            else begin
              grp <= '0;
              if (!ox_w) ox <= ox + DW'(1);
              else begin
                ox <= '0;
                if (!oy_w) oy <= oy + DW'(1);
                else oy <= '0;
              end
            end
          end
        end
      end
    end
  end

  logic [OFF_W-1:0]  row, col;
  logic [WOFF_W-1:0] kkc;

  always_comb begin
    row    = (OFF_W'(oy) << 1) + OFF_W'(ky);
    col    = (OFF_W'(ox) << 1) + OFF_W'(kx);
    fm_off = (row * OFF_W'(in_w) + col) * OFF_W'(in_cw) + OFF_W'(cw);
    kkc    = WOFF_W'(ksz) * WOFF_W'(ksz) * WOFF_W'(in_cw);
    wt_off = WOFF_W'(grp) * kkc
           + (WOFF_W'(ky) * WOFF_W'(ksz) + WOFF_W'(kx)) * WOFF_W'(in_cw)
           + WOFF_W'(cw);
  end

  assign beat_first = (cw == '0) && (kx == '0) && (ky == '0);
  assign beat_last  = cw_w && kx_w && ky_w;
  assign layer_end  = beat_last && g_w && ox_w && oy_w;

  // After a completed dot product that is not the layer's last, the next beat opens a new one
  p_next_is_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && beat_last && !layer_end && !clr) |=> beat_first);
endmodule

// File: rtl/seqr_fc_agen.sv
module seqr_fc_agen #(
  parameter int DW     = 6,
  parameter int OFF_W  = 11,
  parameter int WOFF_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [OFF_W-1:0]  vec_len,
  input  logic [DW-1:0]     groups,
  output logic [OFF_W-1:0]  fm_off,
  output logic [WOFF_W-1:0] wt_off,
  output logic              beat_first,
  output logic              beat_last,
  output logic              layer_end
);
  logic [OFF_W-1:0] idx;
  logic [DW-1:0]    grp;
  logic idx_w, g_w;

  assign idx_w = (idx == vec_len - OFF_W'(1));
  assign g_w   = (grp == groups - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; grp <= '0;
    end else if (clr) begin
      idx <= '0; grp <= '0;
    end else if (step) begin
      if (!idx_w) idx <= idx + OFF_W'(1);
      else begin
        idx <= '0;
        grp <= g_w ? '0 : grp + DW'(1);
      end
    end
  end

  assign fm_off     = idx;
  assign wt_off     = WOFF_W'(grp) * WOFF_W'(vec_len) + WOFF_W'(idx);
  assign beat_first = (idx == '0);
  assign beat_last  = idx_w;
  assign layer_end  = idx_w && g_w;

  // Inside one dot product the flattened input is walked one word at a time
  p_fc_sequential_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !beat_last && !clr) |=> (fm_off == $past(fm_off) + OFF_W'(1)));
endmodule

// File: rtl/seqr_packer.sv
module seqr_packer #(
  parameter int NPE   = 2,
  parameter int VPW   = 4,
  parameter int FM_AW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [FM_AW-1:0]     base,
  input  logic                 res_valid,
  input  logic [2*NPE-1:0]     res_data,
  output logic                 wr_en,
  output logic [FM_AW-1:0]     wr_addr,
  output logic [2*VPW-1:0]     wr_data,
  output logic [FM_AW-1:0]     words
);
  localparam int RW    = 2 * NPE;
  localparam int WW    = 2 * VPW;
  localparam int SLOTS = VPW / NPE;
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SW-1:0]    slot;
  logic [WW-1:0]    acc, merged;
  logic [FM_AW-1:0] wbase, wcnt;
  logic             full;

  assign full = (slot == SW'(SLOTS - 1));

  always_comb begin
    merged = acc;
    merged[slot*RW +: RW] = res_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0; acc <= '0; wbase <= '0; wcnt <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (clr) begin
        slot  <= '0;
        acc   <= '0;
        wcnt  <= '0;
        wbase <= base;
      end else if (res_valid) begin
        acc <= merged;
        if (full) begin
          slot    <= '0;
          wr_en   <= 1'b1;
          wr_addr <= wbase + wcnt;
          wr_data <= merged;
          wcnt    <= wcnt + FM_AW'(1);
        end else begin
          slot <= slot + SW'(1);
        end
      end
    end
  end

  assign words = wcnt;

  // A packed word only leaves after the result that completed it
  p_write_has_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(res_valid));
endmodule

// File: rtl/tern_layer_seq.sv
module tern_layer_seq
  import seqr_pkg::*;
#(
  parameter int NPE   = 2,
  parameter int VPW   = 4,
  parameter int DW    = 6,
  parameter int FM_AW = 12,
  parameter int WT_AW = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_LAYERS*DW-1:0]  cfg_h,
  input  logic [NUM_LAYERS*DW-1:0]  cfg_w,
  input  logic [NUM_LAYERS*DW-1:0]  cfg_cw,
  input  logic [NUM_LAYERS*DW-1:0]  cfg_k,
  input  logic [NUM_LAYERS*DW-1:0]  cfg_oc,
  output logic                      busy,
  output logic [LAYER_W-1:0]        cur_layer,
  output logic                      iss_valid,
  input  logic                      iss_ready,
  output logic [FM_AW-1:0]          fm_rd_addr,
  output logic [WT_AW-1:0]          wt_addr,
  output logic                      pe_first,
  output logic                      pe_last,
  input  logic                      res_valid,
  input  logic [2*NPE-1:0]          res_data,
  output logic                      fm_wr_en,
  output logic [FM_AW-1:0]          fm_wr_addr,
  output logic [2*VPW-1:0]          fm_wr_data,
  output logic                      done
);
  localparam int OFF_W = FM_AW - 1;
  localparam int PSH   = $clog2(NPE);
  localparam int VSH   = $clog2(VPW);
  localparam logic [FM_AW-1:0] REGION = FM_AW'(1) << (FM_AW - 1);

  seq_state_e          state;
  logic [LAYER_W-1:0]  lay;
  logic [WT_AW-1:0]    wbase;
  logic                done_q;

  // Shape table, captured at start
  logic [DW-1:0] t_h [NUM_LAYERS];
  logic [DW-1:0] t_w [NUM_LAYERS];
  logic [DW-1:0] t_cw[NUM_LAYERS];
  logic [DW-1:0] t_k [NUM_LAYERS];
  logic [DW-1:0] t_oc[NUM_LAYERS];

  logic load;
  assign load = (state == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LAYERS; l++) begin
        t_h[l] <= '0; t_w[l] <= '0; t_cw[l] <= '0; t_k[l] <= '0; t_oc[l] <= '0;
      end
    end else if (load) begin
      for (int l = 0; l < NUM_LAYERS; l++) begin
        t_h[l]  <= cfg_h [l*DW +: DW];
        t_w[l]  <= cfg_w [l*DW +: DW];
        t_cw[l] <= cfg_cw[l*DW +: DW];
        t_k[l]  <= cfg_k [l*DW +: DW];
        t_oc[l] <= cfg_oc[l*DW +: DW];
      end
    end
  end

  // Current layer geometry
  logic [DW-1:0]    c_h, c_w, c_cw, c_k, c_oc, o_h, o_w, grps;
  logic [OFF_W-1:0] fc_len;
  logic [FM_AW-1:0] exp_words;
  logic [WT_AW-1:0] layer_wt;
  logic             is_fc;

  always_comb begin
    c_h      = t_h[lay];
    c_w      = t_w[lay];
    c_cw     = t_cw[lay];
    c_k      = t_k[lay];
    c_oc     = t_oc[lay];
    o_h      = ((c_h - c_k) >> 1) + DW'(1);
    o_w      = ((c_w - c_k) >> 1) + DW'(1);
    grps     = c_oc >> PSH;
    is_fc    = (lay == LAYER_W'(NUM_CONV));
    fc_len   = OFF_W'(c_h) * OFF_W'(c_w) * OFF_W'(c_cw);
    layer_wt = WT_AW'(grps) * WT_AW'(c_k) * WT_AW'(c_k) * WT_AW'(c_cw);
    if (is_fc) exp_words = FM_AW'(c_oc) >> VSH;
    else       exp_words = (FM_AW'(o_h) * FM_AW'(o_w) * FM_AW'(c_oc)) >> VSH;
  end

  // Generators and packer
  logic             step, gen_clr, drain_done, advance, finish;
  logic [OFF_W-1:0] cv_fm, fc_fm;
  logic [WT_AW-1:0] cv_wt, fc_wt;
  logic             cv_first, cv_last, cv_end, fc_first, fc_last, fc_end, gen_end;
  logic [FM_AW-1:0] pk_words, pk_base;

  assign step    = iss_valid && iss_ready;
  assign gen_clr = load || advance;

  seqr_conv_agen #(.DW(DW), .OFF_W(OFF_W), .WOFF_W(WT_AW)) i_conv (
    .clk(clk), .rst_n(rst_n), .clr(gen_clr), .step(step && !is_fc),
    .in_w(c_w), .in_cw(c_cw), .ksz(c_k), .out_h(o_h), .out_w(o_w), .groups(grps),
    .fm_off(cv_fm), .wt_off(cv_wt), .beat_first(cv_first), .beat_last(cv_last),
    .layer_end(cv_end)
  );

  seqr_fc_agen #(.DW(DW), .OFF_W(OFF_W), .WOFF_W(WT_AW)) i_fc (
    .clk(clk), .rst_n(rst_n), .clr(gen_clr), .step(step && is_fc),
    .vec_len(fc_len), .groups(grps),
    .fm_off(fc_fm), .wt_off(fc_wt), .beat_first(fc_first), .beat_last(fc_last),
    .layer_end(fc_end)
  );

  assign pk_base = ((state == ST_IDLE) || lay[0]) ? REGION : '0;

  seqr_packer #(.NPE(NPE), .VPW(VPW), .FM_AW(FM_AW)) i_pack (
    .clk(clk), .rst_n(rst_n), .clr(gen_clr), .base(pk_base),
    .res_valid(res_valid), .res_data(res_data),
    .wr_en(fm_wr_en), .wr_addr(fm_wr_addr), .wr_data(fm_wr_data), .words(pk_words)
  );

  assign gen_end    = is_fc ? fc_end : cv_end;
  assign drain_done = (state == ST_DRAIN) && (pk_words == exp_words);
  assign advance    = drain_done && !is_fc;
  assign finish     = drain_done && is_fc;

  // Layer schedule
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lay    <= '0;
      wbase  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          lay   <= '0;
          wbase <= '0;
        end
        ST_RUN: if (step && gen_end) state <= ST_DRAIN;
        ST_DRAIN: if (finish) begin
          state <= ST_IDLE;
          lay   <= '0;
        end else if (advance) begin
          state <= ST_RUN;
          lay   <= lay + LAYER_W'(1);
          wbase <= wbase + layer_wt;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign cur_layer  = lay;
  assign iss_valid  = (state == ST_RUN);
  assign fm_rd_addr = (lay[0] ? REGION : '0) + FM_AW'(is_fc ? fc_fm : cv_fm);
  assign wt_addr    = wbase + (is_fc ? fc_wt : cv_wt);
  assign pe_first   = is_fc ? fc_first : cv_first;
  assign pe_last    = is_fc ? fc_last : cv_last;
  assign done       = done_q;

  // A stalled beat keeps its contents
  p_hold_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(fm_rd_addr) && $stable(wt_addr)
                                   && $stable(pe_first) && $stable(pe_last)));

  // Write-back never lands in the region being read
  p_pingpong_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fm_wr_en |-> (fm_wr_addr[FM_AW-1] != fm_rd_addr[FM_AW-1]));

  // Completion follows the final write
  p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(fm_wr_en) && !busy));

  // Layers advance one at a time or return to the start
  p_layer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_layer) |-> ((cur_layer == $past(cur_layer) + LAYER_W'(1)) || (cur_layer == '0)));
endmodule

// File: tb/test_tern_layer_seq.sv
module test_tern_layer_seq;
  localparam int NPE = 2, VPW = 4, DW = 6, FM_AW = 12, WT_AW = 14;
  localparam int NL = 5, MAXI = 4096, MAXW = 1024, MAXR = 2048, REG = 2048;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NL*DW-1:0] cfg_h = '0, cfg_w = '0, cfg_cw = '0, cfg_k = '0, cfg_oc = '0;
  logic busy, iss_valid, iss_ready = 0, pe_first, pe_last, res_valid = 0, fm_wr_en, done;
  logic [2:0] cur_layer;
  logic [FM_AW-1:0] fm_rd_addr, fm_wr_addr;
  logic [WT_AW-1:0] wt_addr;
  logic [2*NPE-1:0] res_data = '0;
  logic [2*VPW-1:0] fm_wr_data;

  always #5 clk = ~clk;

  tern_layer_seq #(.NPE(NPE), .VPW(VPW), .DW(DW), .FM_AW(FM_AW), .WT_AW(WT_AW)) i_tern_layer_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_h(cfg_h), .cfg_w(cfg_w), .cfg_cw(cfg_cw), .cfg_k(cfg_k), .cfg_oc(cfg_oc),
    .busy(busy), .cur_layer(cur_layer), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .fm_rd_addr(fm_rd_addr), .wt_addr(wt_addr), .pe_first(pe_first), .pe_last(pe_last),
    .res_valid(res_valid), .res_data(res_data), .fm_wr_en(fm_wr_en), .fm_wr_addr(fm_wr_addr),
    .fm_wr_data(fm_wr_data), .done(done)
  );

  int nchk = 0, nfail = 0;
  int sh[NL], sw[NL], scw[NL], sk[NL], soc[NL];
  int e_fm[MAXI], e_wt[MAXI], e_ly[MAXI];
  bit e_f[MAXI], e_l[MAXI];
  int e_wa[MAXW], e_wd[MAXW], cum[NL];
  logic [2*NPE-1:0] rv[MAXR];
  int ni, nw, gi, wi, ri, pend, run_cyc;
  bit last_wr, seen_done, hold_v, perturb, all_ready, dog;
  int hold_fm, hold_wt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_expected();
    int wb, rp;
    ni = 0; nw = 0; wb = 0; rp = 0;
    for (int r = 0; r < MAXR; r++) rv[r] = 4'($urandom);
    for (int l = 0; l < NL; l++) begin
      int rdb, wrb, oh, ow, gr, nres;
      cum[l] = nw;
      rdb = (l % 2) ? REG : 0;
      wrb = (l % 2) ? 0 : REG;
      gr  = soc[l] / NPE;
      if (l < 4) begin
        oh = (sh[l] - sk[l]) / 2 + 1;
        ow = (sw[l] - sk[l]) / 2 + 1;
        for (int oy = 0; oy < oh; oy++)
          for (int ox = 0; ox < ow; ox++)
            for (int g = 0; g < gr; g++)
              for (int ky = 0; ky < sk[l]; ky++)
                for (int kx = 0; kx < sk[l]; kx++)
                  for (int c = 0; c < scw[l]; c++) begin
                    e_fm[ni] = rdb + ((2*oy+ky)*sw[l] + 2*ox+kx)*scw[l] + c;
                    e_wt[ni] = wb + g*sk[l]*sk[l]*scw[l] + (ky*sk[l]+kx)*scw[l] + c;
                    e_f[ni]  = (ky == 0 && kx == 0 && c == 0);
                    e_l[ni]  = (ky == sk[l]-1 && kx == sk[l]-1 && c == scw[l]-1);
                    e_ly[ni] = l; ni++;
                  end
        nres = oh * ow * gr;
        wb += gr * sk[l] * sk[l] * scw[l];
      end else begin
        int len;
        len = sh[l] * sw[l] * scw[l];
        for (int g = 0; g < gr; g++)
          for (int i = 0; i < len; i++) begin
            e_fm[ni] = rdb + i; e_wt[ni] = wb + g*len + i;
            e_f[ni] = (i == 0); e_l[ni] = (i == len-1); e_ly[ni] = l; ni++;
          end
        nres = gr;
      end
      for (int j = 0; j < nres / 2; j++) begin
        e_wa[nw] = wrb + j;
        e_wd[nw] = {rv[rp + 2*j + 1], rv[rp + 2*j]};
        nw++;
      end
      rp += nres;
    end
  endtask

  task automatic load_cfg();
    for (int l = 0; l < NL; l++) begin
      cfg_h[l*DW +: DW] = DW'(sh[l]); cfg_w[l*DW +: DW] = DW'(sw[l]);
      cfg_cw[l*DW +: DW] = DW'(scw[l]); cfg_k[l*DW +: DW] = DW'(sk[l]);
      cfg_oc[l*DW +: DW] = DW'(soc[l]);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    run_cyc++;
    if (hold_v) begin
      chk(iss_valid && int'(fm_rd_addr) == hold_fm && int'(wt_addr) == hold_wt,
          "R7 stalled beat", int'(fm_rd_addr), hold_fm);
      hold_v = 0;
    end
    start = (run_cyc == 1) || (perturb && run_cyc == 40);   // R11: second pulse while busy
    if (perturb && run_cyc == 25) begin                     // R12: scramble config mid-run
      cfg_h = ~cfg_h; cfg_w = ~cfg_w; cfg_cw = ~cfg_cw; cfg_k = ~cfg_k; cfg_oc = ~cfg_oc;
    end
    iss_ready = all_ready ? 1'b1 : (($urandom % 4) != 0);
    if (pend > 0 && ($urandom % 2) == 1) begin
      res_valid = 1; res_data = rv[ri]; ri++; pend--;
    end else res_valid = 0;
    if (iss_valid && iss_ready) begin
      if (gi >= ni) chk(0, "R2 extra beat", gi, ni);
      else begin
        if (gi > 0 && e_ly[gi] != e_ly[gi-1])
          chk(wi == cum[e_ly[gi]], "R10 previous layer written", wi, cum[e_ly[gi]]);
        chk(int'(cur_layer) == e_ly[gi], "R2 layer index", int'(cur_layer), e_ly[gi]);
        chk(int'(fm_rd_addr) == e_fm[gi], e_ly[gi] == 4 ? "R5 fc read" : "R3 conv read",
            int'(fm_rd_addr), e_fm[gi]);
        chk(int'(fm_rd_addr[FM_AW-1]) == e_ly[gi] % 2, "R9 read region",
            int'(fm_rd_addr[FM_AW-1]), e_ly[gi] % 2);
        chk(int'(wt_addr) == e_wt[gi], "R4 weight address", int'(wt_addr), e_wt[gi]);
        chk(pe_first == e_f[gi] && pe_last == e_l[gi], "R6 markers",
            {pe_first, pe_last}, {e_f[gi], e_l[gi]});
      end
      if (pe_last) pend++;
      gi++;
    end else if (iss_valid) begin
      hold_v = 1; hold_fm = int'(fm_rd_addr); hold_wt = int'(wt_addr);
    end
    if (fm_wr_en) begin
      if (wi >= nw) chk(0, "R8 extra write", wi, nw);
      else begin
        chk(int'(fm_wr_addr) == e_wa[wi], "R9 write address", int'(fm_wr_addr), e_wa[wi]);
        chk(int'(fm_wr_data) == e_wd[wi], "R8 packed data", int'(fm_wr_data), e_wd[wi]);
      end
      wi++;
    end
    if (done) begin
      chk(last_wr && wi == nw, "R10 done after final write", wi, nw);
      seen_done = 1;
    end
    last_wr = fm_wr_en;
  endtask

  task automatic do_run();
    build_expected();
    load_cfg();
    gi = 0; wi = 0; ri = 0; pend = 0; run_cyc = 0;
    last_wr = 0; seen_done = 0; hold_v = 0;
    while (!seen_done && run_cyc < 30000) tick();
    if (!seen_done) begin
      chk(0, "R10 watchdog expired", run_cyc, 30000);
      dog = 1;
    end else begin
      tick();
      chk(!done && !busy, "R10 done is one pulse", done, 0);
      chk(gi == ni, perturb ? "R11 beat count" : "R2 beat count", gi, ni);
      chk(wi == nw, perturb ? "R12 write count" : "R8 write count", wi, nw);
    end
    start = 0; res_valid = 0;
  endtask

  task automatic rand_cfg();
    for (int l = 0; l < 4; l++) begin
      sk[l] = 1 + $urandom % 3;
      sh[l] = sk[l] + $urandom % (7 - sk[l]);
      sw[l] = sk[l] + $urandom % (7 - sk[l]);
      scw[l] = 1 + $urandom % 2;
      soc[l] = 4 * (1 + $urandom % 2);
    end
    sk[4] = 1; sh[4] = 1 + $urandom % 3; sw[4] = 1 + $urandom % 3;
    scw[4] = 1 + $urandom % 2; soc[4] = 4 * (1 + $urandom % 2);
  endtask

  initial begin
    void'($urandom(32'd20210126));
    dog = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy, "R1 busy", busy, 0);
    chk(!iss_valid, "R1 iss_valid", iss_valid, 0);
    chk(!fm_wr_en && !done, "R1 write/done", {fm_wr_en, done}, 0);
    chk(cur_layer == 0, "R1 layer", int'(cur_layer), 0);
    rst_n = 1;
    @(negedge clk);

    // Directed: mixed shapes, mid-run start pulse and config scramble (R11, R12)
    sh = '{9, 4, 2, 1, 2}; sw = '{9, 4, 2, 1, 2}; sk = '{3, 2, 2, 1, 1};
    scw = '{2, 2, 1, 1, 1}; soc = '{8, 4, 4, 4, 8};
    perturb = 1; all_ready = 0;
    do_run();

    // Directed corner: one-pixel layers, one-beat dot products, no stalls
    if (!dog) begin
      sh = '{1, 1, 1, 1, 1}; sw = '{1, 1, 1, 1, 1}; sk = '{1, 1, 1, 1, 1};
      scw = '{1, 1, 1, 1, 1}; soc = '{4, 4, 4, 4, 4};
      perturb = 0; all_ready = 1;
      do_run();
    end

    // Random shapes
    for (int n = 0; n < 4 && !dog; n++) begin
      rand_cfg();
      perturb = 0; all_ready = (n == 3);
      do_run();
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule